// File: doc/BRIEF.md
# Split-Section Binary Ripple Counter

A four-bit up counter in two parts that advance independently: a single-bit divide-by-two stage with its own count input, and a three-bit divide-by-eight stage with a second count input. Both parts move on the falling edge of their count input. Each count input is brought into the system clock domain by a two-flop synchronizer, and a falling edge is turned into a one-cycle enable. The counter therefore runs on one system clock and has no internal ripple.

A chain input joins the two parts. When it is high, the lower stage's own 1-to-0 transition advances the upper section in the same system-clock cycle, so the four outputs count 0 to 15 in binary with q[0] as the least significant bit. When it is low, the upper section counts falling edges of its own input. The lower stage then toggles on its own.

Two clear inputs are ANDed. Only when both are high are all stages cleared, and this clear acts at once without waiting for a clock. Leaving the clear state takes two system-clock edges before counting resumes. Count edges that arrive while the clear is held are dropped.

Top module: `split_ripple_counter`

## Requirements
- R1: Each falling edge of `tick_lo` toggles q[0]. If the input falls between two clock edges, q changes at the third rising clock edge after the fall, and not before it.
- R2: With `chain_en` low, each falling edge of `tick_hi` adds one to q[3:1], with the same three-edge latency. The count wraps from 7 to 0.
- R3: A rising edge or a steady level on either count input leaves q unchanged.
- R4: With `chain_en` high, the clock edge that takes q[0] from 1 to 0 also adds one to q[3:1]. Pulses on `tick_lo` then step q through 0 to 15 and wrap from 15 to 0.
- R5: With `chain_en` high, falling edges of `tick_hi` leave q unchanged.
- R6: With `chain_en` low, toggles of q[0] leave q[3:1] unchanged.
- R7: While `clr_a` and `clr_b` are both high, q is 0. It is cleared as soon as both are high, without a clock edge.
- R8: When only one of `clr_a` and `clr_b` is high, the count is not cleared, and counting continues as normal.
- R9: After the clear is released, q stays 0 for the first two rising clock edges. A falling count edge applied while the clear was held never changes the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| tick_lo | input | 1 | Asynchronous count input of the single-bit stage (falling edge counts) |
| tick_hi | input | 1 | Asynchronous count input of the upper section (falling edge counts) |
| chain_en | input | 1 | High: the lower stage drives the upper section; low: the sections are independent |
| clr_a | input | 1 | Clear input, active high, ANDed with clr_b |
| clr_b | input | 1 | Clear input, active high, ANDed with clr_a |
| q | output | 4 | Count: q[0] is the single-bit stage, q[3:1] the upper section |

## Verification
Directed pulses on the lower input with chaining enabled step the counter through all sixteen states and past the wrap. This separates a correct carry from a missing or early one. Pulses on the upper input alone, with chaining off, cross the 7-to-0 wrap; the same pulses with chaining on must do nothing, which shows whether the input mux works. A single pulse is sampled at the second and at the third clock edge after the fall, which pins the latency exactly. A seeded random mix then interleaves pulses on both inputs, mode changes, single-input clears and full clears. The single-input clears show whether the two clear inputs are ANDed or ORed. Edges driven while the clear is held show whether they are dropped.

// File: rtl/split_ripple_counter.sv
module split_ripple_counter #(
  parameter int HI_BITS     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             tick_lo,
  input  logic             tick_hi,
  input  logic             chain_en,
  input  logic             clr_a,
  input  logic             clr_b,
  output logic [HI_BITS:0] q
);

  logic clr_all;
  assign clr_all = clr_a & clr_b;

  logic [1:0] rel_sh;
  logic       run;

  always_ff @(posedge clk or posedge clr_all) begin
    if (clr_all) rel_sh <= '0;
    else         rel_sh <= {rel_sh[0], 1'b1};
  end
  assign run = rel_sh[1];

  logic [SYNC_STAGES:0] sy_lo, sy_hi;

  always_ff @(posedge clk or posedge clr_all) begin
    if (clr_all) begin
      sy_lo <= '0;
      sy_hi <= '0;
    end else begin
      sy_lo <= {sy_lo[SYNC_STAGES-1:0], tick_lo};
      sy_hi <= {sy_hi[SYNC_STAGES-1:0], tick_hi};
    end
  end

  logic fall_lo, fall_hi, hi_en;
  logic lo_q;
  logic [HI_BITS-1:0] hi_q;

  assign fall_lo = run & sy_lo[SYNC_STAGES] & ~sy_lo[SYNC_STAGES-1];
  assign fall_hi = run & sy_hi[SYNC_STAGES] & ~sy_hi[SYNC_STAGES-1];
  assign hi_en   = chain_en ? (fall_lo & lo_q) : fall_hi;

  always_ff @(posedge clk or posedge clr_all) begin
    if (clr_all) begin
      lo_q <= 1'b0;
      hi_q <= '0;
    end else begin
      if (fall_lo) lo_q <= ~lo_q;
      if (hi_en)   hi_q <= hi_q + 1'b1;
    end
  end

  assign q = {hi_q, lo_q};

endmodule

// File: rtl/split_ripple_counter_chk.sv
module split_ripple_counter_chk #(
  parameter int HI_BITS = 3
) (
  input logic             clk,
  input logic             chain_en,
  input logic             clr_a,
  input logic             clr_b,
  input logic [HI_BITS:0] q
);

  logic clr_all;
  assign clr_all = clr_a & clr_b;

  always @(posedge clk) begin
    if (clr_all) begin
      assert_cleared_R7: assert (q == '0);
    end
  end

  assert_hi_step_R2: assert property (@(posedge clk) disable iff (clr_all)
    (q[HI_BITS:1] != $past(q[HI_BITS:1])) |->
      (q[HI_BITS:1] == $past(q[HI_BITS:1]) + 1'b1));

  assert_chain_carry_R4: assert property (@(posedge clk) disable iff (clr_all)
    ($past(chain_en) && (q[HI_BITS:1] != $past(q[HI_BITS:1]))) |-> $fell(q[0]));

  assert_chain_lo_fall_R4: assert property (@(posedge clk) disable iff (clr_all)
    ($past(chain_en) && $fell(q[0])) |-> (q[HI_BITS:1] != $past(q[HI_BITS:1])));

  assert_release_hold_R9: assert property (@(posedge clk)
    $past(clr_all) |-> (q == '0));

endmodule

bind split_ripple_counter split_ripple_counter_chk #(.HI_BITS(HI_BITS)) u_chk (
  .clk(clk), .chain_en(chain_en), .clr_a(clr_a), .clr_b(clr_b), .q(q)
);

// File: tb/sim_split_ripple_counter.sv
module sim_split_ripple_counter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic tick_lo = 1'b1, tick_hi = 1'b1, chain_en = 1'b0;
  logic clr_a = 1'b1, clr_b = 1'b1;
  logic [3:0] q;

  int n_chk = 0, n_bad = 0;
  logic       m_lo = 1'b0;
  logic [2:0] m_hi = 3'd0;

  split_ripple_counter u0 (
    .clk(clk), .tick_lo(tick_lo), .tick_hi(tick_hi), .chain_en(chain_en),
    .clr_a(clr_a), .clr_b(clr_b), .q(q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] model_q();
    return {m_hi, m_lo};
  endfunction

  task automatic check(input string tag, input logic [3:0] exp);
    n_chk++;
    if (q !== exp) begin
      n_bad++;
      $display("FAIL %s: q=%0d expected %0d", tag, q, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_lo(input string tag);
    @(negedge clk); tick_lo = 1'b0;
    if (m_lo && chain_en) m_hi = m_hi + 3'd1;
    m_lo = ~m_lo;
    cyc(4); check(tag, model_q());
    tick_lo = 1'b1;
    cyc(4); check({tag, " rise"}, model_q());
  endtask

  task automatic pulse_hi(input string tag);
    @(negedge clk); tick_hi = 1'b0;
    if (!chain_en) m_hi = m_hi + 3'd1;
    cyc(4); check(tag, model_q());
    tick_hi = 1'b1;
    cyc(4); check({tag, " rise"}, model_q());
  endtask

  task automatic full_clear(input string tag);
    @(negedge clk); #1;
    clr_a = 1'b1; clr_b = 1'b1;
    #1; m_lo = 1'b0; m_hi = 3'd0;
    check({tag, " immediate"}, 4'd0);
    cyc(3);
    clr_a = 1'b0; clr_b = 1'b0;
    cyc(4);
  endtask

  initial begin
    #(CLK_PERIOD*30000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not end");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    cyc(3);
    check("R7 reset state", 4'd0);
    clr_a = 1'b0; clr_b = 1'b0;
    cyc(4);
    check("R9 after release", 4'd0);

    // R1 exact latency
    @(negedge clk); tick_lo = 1'b0;
    cyc(2); check("R1 not yet at second edge", 4'd0);
    cyc(1); check("R1 toggled at third edge", 4'd1);
    m_lo = 1'b1;
    tick_lo = 1'b1; cyc(4);
    check("R3 rising edge ignored", model_q());

    // R6: independent mode, lower toggles leave upper
    pulse_lo("R6 lower toggle, upper unchanged");

    // R2 with wrap
    for (int i = 0; i < 9; i++) pulse_hi("R2 upper count");
    check("R2 wrap 7->0", {3'd1, m_lo});

    // R4 chain full sweep
    full_clear("R7");
    chain_en = 1'b1;
    for (int i = 0; i < 17; i++) pulse_lo("R4 chained count");
    check("R4 wrap 15->0", 4'd1);

    // R5
    pulse_hi("R5 tick_hi ignored in chain mode");

    // R8
    @(negedge clk); clr_a = 1'b1; cyc(3);
    check("R8 clr_a alone", model_q());
    pulse_lo("R8 counting with clr_a alone");
    clr_a = 1'b0; clr_b = 1'b1; cyc(3);
    check("R8 clr_b alone", model_q());
    clr_b = 1'b0; cyc(2);

    // R9 edges during clear dropped
    chain_en = 1'b0;
    @(negedge clk); clr_a = 1'b1; clr_b = 1'b1;
    m_lo = 1'b0; m_hi = 3'd0;
    cyc(1); tick_hi = 1'b0; tick_lo = 1'b0;
    cyc(4); check("R7 held clear", 4'd0);
    clr_a = 1'b0; clr_b = 1'b0;
    cyc(1); check("R9 hold first edge", 4'd0);
    cyc(1); check("R9 hold second edge", 4'd0);
    cyc(4); check("R9 edges during clear dropped", 4'd0);
    tick_hi = 1'b1; tick_lo = 1'b1; cyc(4);
    check("R3 rise after clear", 4'd0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom_range(0, 9));
      case (op)
        0, 1, 2, 3: pulse_lo("R1/R4 random lower pulse");
        4, 5:       pulse_hi("R2/R5 random upper pulse");
        6: begin @(negedge clk); chain_en = ~chain_en; cyc(1); check("R3 mode change", model_q()); end
        7: begin
          @(negedge clk);
          if ($urandom_range(0, 1) == 0) clr_a = 1'b1; else clr_b = 1'b1;
          cyc(3); check("R8 random single clear", model_q());
          clr_a = 1'b0; clr_b = 1'b0; cyc(1);
        end
        8: if ($urandom_range(0, 3) == 0) full_clear("R7 random");
        default: begin cyc(3); check("R3 idle", model_q()); end
      endcase
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule